// File: doc/BRIEF.md
# Clamped IIR Compensator with Gain Input

This block is the compensation filter of a voltage-mode digital power converter loop. Each control period begins with a `trigger` pulse. The block first works through the output-history half of a direct-form IIR filter (the A-term). This runs while the converter's feedback sample is still being converted.

When `sample_valid` reports the new feedback sample, the block forms the error as reference minus feedback. It then accumulates the error-history half (the B-term) and multiplies that sum by an externally supplied run-time gain factor. It adds the product to the precomputed A-term, scales the result back to sample width, saturates it, and clamps it between two programmable limits. The clamped value is the new duty-cycle command.

Filter coefficients, gain and limits arrive on ports. One multiply-accumulate unit per term is reused serially, one tap per cycle. A controller sequences the work through seven states:

- `ST_IDLE`: waits for a trigger.
- `ST_ATERM`: accumulates the output history.
- `ST_WAIT`: waits for the sample.
- `ST_BTERM`: accumulates the error history.
- `ST_SCALE`: applies the gain.
- `ST_CLAMP`: saturates, limits, writes the output and shifts both histories.
- `ST_DONE`: raises the done pulse on its exit edge.

The transitions are:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_ATERM` | trigger |
| `ST_ATERM` | `ST_WAIT` | last A tap |
| `ST_WAIT` | `ST_BTERM` | sample_valid |
| `ST_BTERM` | `ST_SCALE` | last B tap |
| `ST_SCALE` | `ST_CLAMP` | always |
| `ST_CLAMP` | `ST_DONE` | always |
| `ST_DONE` | `ST_IDLE` | always |
| any | `ST_IDLE` | enable low |

Top module: `iir_comp`

## Requirements
- R1: When a sample is accepted, the error is reference minus feedback, saturated to the signed 16-bit range (-32768..32767).
- R2: `sample_valid` is taken only in the first cycle after the NA A-term cycles in which it is high. A pulse that arrives together with the trigger or during the A-term is ignored, and the run waits for a later one.
- R3: The raw result is floor((A + floor(B*G/2^12)) / 2^15). Here A = sum of a_i*y[n-1-i] and B = sum of b_j*e[n-j]. The coefficients are signed Q15, with coefficient i at bits [16i+15:16i] of its bus. The gain G is unsigned with 12 fraction bits.
- R4: The raw result is saturated to -32768..32767 before the limits are applied.
- R5: A saturated value above `lim_max` is replaced by `lim_max`, and one below `lim_min` by `lim_min`.
- R6: The output history stores the clamped value, so the results after a clamp are computed from the limit and not from the raw value.
- R7: With `sample_valid` already high, `duty_valid` rises NA+NB+4 cycles (9 by default) after the edge that sees `trigger`. It is high for one cycle, and `duty` holds its value between results.
- R8: A trigger that arrives while a run is in progress has no effect: it neither starts a second run nor shifts the timing of the current one.
- R9: While `enable` is low, `duty` equals `lim_min` from the next cycle on, no result is produced, and both histories are cleared. The first run after re-enabling starts from zero history.
- R10: `done` is high for exactly the cycle after each `duty_valid` cycle.
- R11: After reset, `duty` is 0 and `duty_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Filter run enable; low selects the bypass |
| trigger | input | 1 | Start of control period |
| sample_valid | input | 1 | Feedback sample is valid |
| feedback | input | 16 | Signed feedback sample |
| reference | input | 16 | Signed reference |
| gain | input | 16 | Unsigned gain factor, 12 fraction bits |
| coef_a | input | NA*16 | Output-history coefficients, Q15 |
| coef_b | input | NB*16 | Error-history coefficients, Q15 |
| lim_min | input | 16 | Signed lower duty limit |
| lim_max | input | 16 | Signed upper duty limit |
| duty | output | 16 | Signed clamped duty command |
| duty_valid | output | 1 | New duty value this cycle |
| done | output | 1 | Run finished (cycle after duty_valid) |

## Verification
A fault in either delay line shows up only in the result of the run after the one that corrupted it. The bench therefore walks a sequence of runs with a software model that carries its own history. A fault in the clamp feedback shows up first in the run right after a clamping result.

A wrong state-sequencing decision, such as an early sample taken or a retrigger honoured, shows up as a latency other than the expected one on `duty_valid`. It can also show up as an extra result within about a dozen cycles. A bypass fault appears on `duty` one cycle after `enable` falls, and a history left uncleared appears in the first result after re-enabling.

// File: rtl/comp_pkg.sv
package comp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ATERM,
        ST_WAIT,
        ST_BTERM,
        ST_SCALE,
        ST_CLAMP,
        ST_DONE
    } comp_state_e;
endpackage

// File: rtl/comp_mac.sv
module comp_mac #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int AW = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [CW-1:0] coef,
    input  logic signed [DW-1:0] data,
    output logic signed [AW-1:0] acc
);
    localparam int PW = DW + CW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    assign prod     = coef * data;
    assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod_ext;
        end
    end
endmodule

// File: rtl/comp_hist.sv
module comp_hist #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      shift,
    input  logic [W-1:0]              d,
    output logic [DEPTH-1:0][W-1:0]   q
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (clr) begin
                q[i] <= '0;
            end else if (shift) begin
                if (i == 0) q[i] <= d;
                else        q[i] <= q[(i > 0) ? i-1 : 0];
            end
        end
    end

    // R6: the newest tap takes exactly what the controller offered
    assert_hist_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr) |=> (q[0] == $past(d)));

    // R9: a clear leaves every tap at zero
    assert_hist_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
endmodule

// File: rtl/comp_limit.sv
module comp_limit #(
    parameter int IW = 58,
    parameter int DW = 16
) (
    input  logic signed [IW-1:0] raw,
    input  logic signed [DW-1:0] lo,
    input  logic signed [DW-1:0] hi,
    output logic signed [DW-1:0] y
);
    localparam logic signed [IW-1:0] SAT_HI = {{(IW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [IW-1:0] SAT_LO = {{(IW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW-1:0] sat;

    always_comb begin
        if (raw > SAT_HI)      sat = SAT_HI[DW-1:0];
        else if (raw < SAT_LO) sat = SAT_LO[DW-1:0];
        else                   sat = raw[DW-1:0];

        if (sat > hi)          y = hi;
        else if (sat < lo)     y = lo;
        else                   y = sat;
    end
endmodule

// File: rtl/iir_comp.sv
module iir_comp #(
    parameter int DW        = 16,
    parameter int CW        = 16,
    parameter int GW        = 16,
    parameter int GAIN_FRAC = 12,
    parameter int COEF_FRAC = 15,
    parameter int NA        = 2,
    parameter int NB        = 3,
    parameter int AW        = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 trigger,
    input  logic                 sample_valid,
    input  logic signed [DW-1:0] feedback,
    input  logic signed [DW-1:0] reference,
    input  logic [GW-1:0]        gain,
    input  logic [NA*CW-1:0]     coef_a,
    input  logic [NB*CW-1:0]     coef_b,
    input  logic signed [DW-1:0] lim_min,
    input  logic signed [DW-1:0] lim_max,
    output logic signed [DW-1:0] duty,
    output logic                 duty_valid,
    output logic                 done
);
    import comp_pkg::*;

    localparam int MAXN = (NA > NB) ? NA : NB;
    localparam int IDXW = ($clog2(MAXN) < 1) ? 1 : $clog2(MAXN);
    localparam int PGW  = AW + GW + 1;
    localparam int SW   = AW + GW + 2;
    localparam int EHD  = NB - 1;
    localparam logic signed [DW:0] ERR_HI = {2'b00, {(DW-1){1'b1}}};
    localparam logic signed [DW:0] ERR_LO = {2'b11, {(DW-1){1'b0}}};

    comp_state_e state_q, state_d;
    logic [IDXW-1:0] idx_q;
    logic signed [DW-1:0] err_q;
    logic signed [SW-1:0] scaled_q;

    logic [NA-1:0][DW-1:0] y_hist;
    logic [EHD-1:0][DW-1:0] e_hist;
    logic [NB-1:0][DW-1:0] e_vec;

    logic signed [DW:0]   err_diff;
    logic signed [DW-1:0] err_sat;
    logic signed [CW-1:0] a_coef, b_coef;
    logic signed [DW-1:0] a_data, b_data;
    logic signed [AW-1:0] acc_a, acc_b;
    logic signed [PGW-1:0] prod_g, prod_sh;
    logic signed [SW-1:0] sum_raw, raw_sc;
    logic signed [DW-1:0] lim_y;
    logic a_last, b_last, start, accept, commit;

    // ---------------- error formation ----------------
    assign err_diff = {reference[DW-1], reference} - {feedback[DW-1], feedback};
    always_comb begin
        if (err_diff > ERR_HI)      err_sat = ERR_HI[DW-1:0];
        else if (err_diff < ERR_LO) err_sat = ERR_LO[DW-1:0];
        else                        err_sat = err_diff[DW-1:0];
    end

    // ---------------- tap selection ----------------
    assign e_vec[0] = err_q;
    for (genvar j = 1; j < NB; j++) begin : g_evec
        assign e_vec[j] = e_hist[j-1];
    end

    always_comb begin
        a_coef = '0;
        a_data = '0;
        for (int i = 0; i < NA; i++) begin
            if (idx_q == IDXW'(i)) begin
                a_coef = coef_a[i*CW +: CW];
                a_data = y_hist[i];
            end
        end
        b_coef = '0;
        b_data = '0;
        for (int i = 0; i < NB; i++) begin
            if (idx_q == IDXW'(i)) begin
                b_coef = coef_b[i*CW +: CW];
                b_data = e_vec[i];
            end
        end
    end

    assign a_last = (idx_q == IDXW'(NA-1));
    assign b_last = (idx_q == IDXW'(NB-1));
    assign start  = enable && (state_q == ST_IDLE) && trigger;
    assign accept = enable && (state_q == ST_WAIT) && sample_valid;
    assign commit = enable && (state_q == ST_CLAMP);

    // ---------------- accumulators ----------------
    comp_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (enable && (state_q == ST_ATERM)),
        .coef  (a_coef),
        .data  (a_data),
        .acc   (acc_a)
    );

    comp_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (enable && (state_q == ST_BTERM)),
        .coef  (b_coef),
        .data  (b_data),
        .acc   (acc_b)
    );

    // ---------------- gain, combine, limit ----------------
    assign prod_g  = acc_b * $signed({1'b0, gain});
    assign prod_sh = prod_g >>> GAIN_FRAC;
    assign sum_raw = scaled_q + {{(SW-AW){acc_a[AW-1]}}, acc_a};
    assign raw_sc  = sum_raw >>> COEF_FRAC;

    comp_limit #(.IW(SW), .DW(DW)) u_limit (
        .raw (raw_sc),
        .lo  (lim_min),
        .hi  (lim_max),
        .y   (lim_y)
    );

    // ---------------- histories ----------------
    comp_hist #(.W(DW), .DEPTH(NA)) u_yhist (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!enable),
        .shift (commit),
        .d     (lim_y),
        .q     (y_hist)
    );

    comp_hist #(.W(DW), .DEPTH(EHD)) u_ehist (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!enable),
        .shift (commit),
        .d     (err_q),
        .q     (e_hist)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (trigger)      state_d = ST_ATERM;
                ST_ATERM: if (a_last)       state_d = ST_WAIT;
                ST_WAIT:  if (sample_valid) state_d = ST_BTERM;
                ST_BTERM: if (b_last)       state_d = ST_SCALE;
                ST_SCALE:                   state_d = ST_CLAMP;
                ST_CLAMP:                   state_d = ST_DONE;
                ST_DONE:                    state_d = ST_IDLE;
                default:                    state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- outputs and datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty       <= '0;
            duty_valid <= 1'b0;
            done       <= 1'b0;
            idx_q      <= '0;
            err_q      <= '0;
            scaled_q   <= '0;
        end else begin
            duty_valid <= 1'b0;
            done       <= 1'b0;
            if (!enable) begin
                duty  <= lim_min;
                idx_q <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE:  idx_q <= '0;
                    ST_ATERM: idx_q <= a_last ? '0 : idx_q + 1'b1;
                    ST_WAIT: begin
                        idx_q <= '0;
                        if (sample_valid) err_q <= err_sat;
                    end
                    ST_BTERM: idx_q <= b_last ? '0 : idx_q + 1'b1;
                    ST_SCALE: scaled_q <= {prod_sh[PGW-1], prod_sh};
                    ST_CLAMP: begin
                        duty       <= lim_y;
                        duty_valid <= 1'b1;
                    end
                    ST_DONE:  done <= 1'b1;
                    default:  idx_q <= '0;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    // R5: every published duty respects the programmed window
    assert_duty_in_limits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_valid && (lim_min <= lim_max)) |-> ((duty >= lim_min) && (duty <= lim_max)));

    // R10: done follows a published result by one cycle
    assert_done_after_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_valid && enable) |=> done);

    // R10: done never appears without a result just before it
    assert_done_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(duty_valid));

    // R9: bypass drives the lower limit and publishes nothing
    assert_bypass_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((duty == $past(lim_min)) && !duty_valid));

    // R7: a result is a single-cycle pulse
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |=> !duty_valid);

    // R7: duty only moves with a result or in bypass
    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !duty_valid) |-> $stable(duty));
endmodule

// File: tb/iir_comp_bench.sv
module iir_comp_bench;
    localparam int NA = 2;
    localparam int NB = 3;
    localparam longint A0 = 16384, A1 = 8192;
    localparam longint B0 = 24576, B1 = -16384, B2 = 4096;
    localparam int NVEC = 8;
    // {reference, feedback, gain}
    localparam logic [47:0] TBL [NVEC] = '{
        {16'd8000,  16'd7000, 16'd4096},
        {16'd8000,  16'd7600, 16'd4096},
        {16'd8000,  16'd8200, 16'd4096},
        {16'd8000,  16'd8000, 16'd8192},
        {16'd12000, 16'd4000, 16'd4096},
        {16'd8000,  16'd8100, 16'd2048},
        {16'd8000,  16'd9000, 16'd4096},
        {16'd8000,  16'd7990, 16'd12288}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic trigger = 1'b0;
    logic sample_valid = 1'b0;
    logic signed [15:0] feedback = '0;
    logic signed [15:0] reference = '0;
    logic [15:0] gain = 16'd4096;
    logic [NA*16-1:0] coef_a;
    logic [NB*16-1:0] coef_b;
    logic signed [15:0] lim_min = 16'sd100;
    logic signed [15:0] lim_max = 16'sd20000;
    logic signed [15:0] duty;
    logic duty_valid;
    logic done;

    int n_chk = 0;
    int n_fail = 0;
    longint yh0 = 0, yh1 = 0, eh0 = 0, eh1 = 0, pend_e = 0;

    always #2.5 clk = ~clk;

    assign coef_a = {16'(A1), 16'(A0)};
    assign coef_b = {16'(B2), 16'(B1), 16'(B0)};

    iir_comp u_iir_comp (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trigger(trigger),
        .sample_valid(sample_valid), .feedback(feedback), .reference(reference),
        .gain(gain), .coef_a(coef_a), .coef_b(coef_b),
        .lim_min(lim_min), .lim_max(lim_max),
        .duty(duty), .duty_valid(duty_valid), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint predict(input longint r, input longint f, input longint g);
        longint e, a, b, s, raw;
        e = sat16(r - f);
        pend_e = e;
        a = A0 * yh0 + A1 * yh1;
        b = B0 * e + B1 * eh0 + B2 * eh1;
        s = (b * g) >>> 12;
        raw = sat16((a + s) >>> 15);
        if (raw > longint'(lim_max)) raw = longint'(lim_max);
        else if (raw < longint'(lim_min)) raw = longint'(lim_min);
        return raw;
    endfunction

    task automatic model_commit(input longint y);
        yh1 = yh0; yh0 = y;
        eh1 = eh0; eh0 = pend_e;
    endtask

    task automatic model_clear();
        yh0 = 0; yh1 = 0; eh0 = 0; eh1 = 0;
    endtask

    // One control period; delay>0 sends a bogus early sample with the trigger
    task automatic do_run(input longint r, input longint f, input longint g,
                          input int delay, input bit retrig, input string req,
                          output longint got);
        int cnt;
        longint exp_y;
        int exp_lat;
        reference = 16'(r);
        gain = 16'(g);
        feedback = (delay != 0) ? ~16'(f) : 16'(f);
        sample_valid = 1'b1;
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        if (delay != 0) begin
            sample_valid = 1'b0;
            feedback = 16'(f);
        end
        cnt = 1;
        while (!duty_valid && cnt < 40) begin
            if (delay != 0 && cnt == delay) sample_valid = 1'b1;
            trigger = (retrig && cnt == 4);
            @(negedge clk);
            cnt++;
        end
        trigger = 1'b0;
        sample_valid = 1'b0;
        exp_y = predict(r, f, g);
        exp_lat = (delay == 0) ? (NA + NB + 4) : (delay + NB + 3);
        chk(longint'(duty) == exp_y, {req, " duty value"}, longint'(duty), exp_y);
        chk(cnt == exp_lat, {req, " R7 latency"}, cnt, exp_lat);
        got = longint'(duty);
        model_commit(exp_y);
        @(negedge clk);
        chk(done == 1'b1 && duty_valid == 1'b0, "R10 done pulse", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint got;
        int extra;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(duty == 16'sd0, "R11 duty at reset", duty, 0);
        chk(duty_valid == 1'b0, "R11 valid at reset", duty_valid, 0);
        chk(done == 1'b0, "R11 done at reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(duty == 16'sd0, "R11 duty after release", duty, 0);

        // R3 table walk with history carried by the model
        for (int i = 0; i < NVEC; i++) begin
            do_run($signed(TBL[i][47:32]), $signed(TBL[i][31:16]), TBL[i][15:0],
                   0, 1'b0, "R3", got);
        end

        // R5 upper clamp, then R6 history holds the clamp
        do_run(30000, 0, 16384, 0, 1'b0, "R5 upper", got);
        chk(got == 20000, "R5 upper clamp", got, 20000);
        do_run(8000, 8000, 4096, 0, 1'b0, "R6 after clamp", got);
        // R5 lower clamp
        do_run(-20000, 12000, 16384, 0, 1'b0, "R5 lower", got);
        chk(got == 100, "R5 lower clamp", got, 100);
        do_run(8000, 8000, 4096, 0, 1'b0, "R6 after low clamp", got);

        // R4 and R1: open window so saturation is visible; error saturates
        lim_min = -16'sd32768;
        lim_max = 16'sd32767;
        do_run(32767, -32768, 65535, 0, 1'b0, "R1 R4 positive", got);
        chk(got == 32767, "R4 positive saturation", got, 32767);
        do_run(-32768, 32767, 65535, 0, 1'b0, "R1 R4 negative", got);
        chk(got == -32768, "R4 negative saturation", got, -32768);
        lim_min = 16'sd100;
        lim_max = 16'sd20000;

        // R2 early sample ignored, late sample taken
        do_run(8000, 7500, 4096, 6, 1'b0, "R2 late sample", got);
        do_run(8000, 8300, 4096, 9, 1'b0, "R2 later sample", got);

        // R8 retrigger while busy
        do_run(8000, 7800, 4096, 0, 1'b1, "R8 retrigger", got);
        extra = 0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (duty_valid) extra++;
        end
        chk(extra == 0, "R8 no second result", extra, 0);

        // R9 bypass
        enable = 1'b0;
        @(negedge clk);
        chk(duty == lim_min, "R9 duty is min", duty, lim_min);
        lim_min = 16'sd250;
        @(negedge clk);
        chk(duty == 16'sd250, "R9 duty tracks min", duty, 250);
        trigger = 1'b1;
        sample_valid = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        extra = 0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (duty_valid || done) extra++;
        end
        sample_valid = 1'b0;
        chk(extra == 0, "R9 no result while disabled", extra, 0);
        chk(duty == 16'sd250, "R9 duty held at min", duty, 250);
        lim_min = 16'sd100;
        enable = 1'b1;
        @(negedge clk);
        model_clear();
        do_run(8000, 7000, 4096, 0, 1'b0, "R9 cleared history", got);
        do_run(8000, 7600, 4096, 0, 1'b0, "R9 second after enable", got);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule